// File: doc/BRIEF.md
# Two-Stage Rotate-Merge Integer Shifter

This block is the shift unit of a 32-bit integer datapath. Every shift and rotate is built from one left-rotation network. The network has two cascaded stages. A fine stage turns the word by 0 to 7 bit positions. A coarse stage then turns it by a whole number of bytes. The coarse stage takes the upper bits of the effective amount and the fine stage takes the lower three, so every rotate amount from 0 to 31 can be reached.

Right-hand operations reuse the left-rotation network with the two's-complement of the amount. A per-bit merge stage then puts a fill value over the bit positions that a shift vacates. The fill is zero for logical shifts and the operand sign for the arithmetic right shift. Rotates keep every bit.

The last multiplexer chooses between the merged shift word and an externally computed adder result. Its output is captured in a result register, so the result appears one clock after the inputs are presented. The surrounding pipeline drives the operation code and the source select. Decode and flags are handled elsewhere.

Top module: `rsh_shift_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result_o` becomes 0 after that edge (synchronous, active-low reset).
- R2: `result_o` changes only at a rising edge and reflects the inputs sampled at that edge, giving one cycle of latency.
- R3: With `src_sel_i` = 1, `result_o` equals `sum_i`, whatever `op_i` and `amount_i` are.
- R4: With `src_sel_i` = 0 and `op_i` = 3'd0 (logical left shift by k = `amount_i`), bits below position k are 0 and bit i (i ≥ k) is operand bit i−k.
- R5: `op_i` = 3'd1 (logical right shift by k): the top k bits are 0 and bit i (i < 32−k) is operand bit i+k.
- R6: `op_i` = 3'd2 (arithmetic right shift by k): the top k bits copy operand bit 31 and the other bits are as in R5.
- R7: `op_i` = 3'd3 (rotate left by k): bit i is operand bit (i−k) mod 32.
- R8: `op_i` = 3'd4 (rotate right by k): bit i is operand bit (i+k) mod 32.
- R9: For `op_i` 3'd0 to 3'd4, an amount of 0 returns the operand unchanged.
- R10: With `src_sel_i` = 0, the unused codes 3'd5 to 3'd7 give a result of 0.
- R11: The rotate amount is the byte part (`amount_i[4:3]` × 8) plus the bit part (`amount_i[2:0]`), and all 32 amounts are correct in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| operand_i | input | 32 | Word to be shifted or rotated |
| amount_i | input | 5 | Shift or rotate amount, 0 to 31 |
| op_i | input | 3 | Operation code (0 SLL, 1 SRL, 2 SRA, 3 ROL, 4 ROR) |
| sum_i | input | 32 | Adder result for the bypass path |
| src_sel_i | input | 1 | 1 selects `sum_i`, 0 selects the shifter |
| result_o | output | 32 | Registered result |

## Verification
A broken row in either rotation stage shows up as a specific set of wrong amounts one cycle after they are applied. A bad fine-stage leg fails every amount that shares its low three bits. A bad byte leg fails a run of eight consecutive amounts. For this reason the rotate sweep covers all 32 amounts in both directions. A mask or fill error appears only on shifts, at the boundary bit k, and a wrong sign source appears only when operand bit 31 is 1. Both of these are caught by patterns that have the sign bit set and clear and that use amounts at 1 and 31. A stuck result register or a faulty bypass select appears on the very next edge as a value that fails to follow `sum_i`.

// File: rtl/rsh_pkg.sv
// Shared definitions for the rotate-merge shifter: operation codes.
package rsh_pkg;
    // Operation codes decoded by the merge stage; 5..7 are unused.
    typedef enum logic [2:0] {
        OP_SLL = 3'd0,
        OP_SRL = 3'd1,
        OP_SRA = 3'd2,
        OP_ROL = 3'd3,
        OP_ROR = 3'd4
    } rsh_op_e;
endpackage

// File: rtl/rsh_bit_rotate.sv
// Fine rotate stage: turns the word left by 0..7 bit positions.
// Each output bit is an 8-input multiplexer. Assumes W >= 8.
module rsh_bit_rotate #(
    parameter int W = 32
) (
    input  logic [W-1:0] d_i,
    input  logic [2:0]   n_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Purpose: select source bit (i - n) mod W for output bit i.
        always_comb begin
            q_o[i] = 1'b0;
            for (int j = 0; j < 8; j++) begin
                if (n_i == 3'(j)) q_o[i] = d_i[(i - j + W) % W];
            end
        end
    end
endmodule

// File: rtl/rsh_byte_rotate.sv
// Coarse rotate stage: turns the word left by whole bytes.
// Assumes W is a multiple of 8; BYTES legs per output bit.
module rsh_byte_rotate #(
    parameter int W     = 32,
    localparam int BYTES = W / 8,
    localparam int CW    = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic [W-1:0]  d_i,
    input  logic [CW-1:0] m_i,
    output logic [W-1:0]  q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Purpose: select source bit (i - 8*m) mod W for output bit i.
        always_comb begin
            q_o[i] = 1'b0;
            for (int j = 0; j < BYTES; j++) begin
                if (m_i == CW'(j)) q_o[i] = d_i[(i - 8 * j + W) % W];
            end
        end
    end
endmodule

// File: rtl/rsh_fill_merge.sv
// Merge stage: per bit, keeps the rotated bit or substitutes the fill value.
// Assumes rot_i is already rotated left by the effective amount, so
// left shifts vacate bits below k and right shifts vacate the top k bits.
module rsh_fill_merge
    import rsh_pkg::*;
#(
    parameter int W = 32,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  rot_i,
    input  logic          sign_i,
    input  logic [2:0]    op_i,
    input  logic [AW-1:0] amt_i,
    output logic [W-1:0]  res_o
);
    logic [W-1:0] lo_mask;
    logic [W-1:0] hi_mask;

    for (genvar i = 0; i < W; i++) begin : g_mask
        // Purpose: flag bit i as vacated for a left or a right shift.
        always_comb begin
            lo_mask[i] = (i < int'(amt_i));
            hi_mask[i] = ((i + int'(amt_i)) >= W);
        end
    end

    // Purpose: choose fill or rotated bit according to the operation.
    always_comb begin
        case (rsh_op_e'(op_i))
            OP_SLL:  res_o = rot_i & ~lo_mask;
            OP_SRL:  res_o = rot_i & ~hi_mask;
            OP_SRA:  res_o = (rot_i & ~hi_mask) | ({W{sign_i}} & hi_mask);
            OP_ROL,
            OP_ROR:  res_o = rot_i;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/rsh_shift_unit.sv
// Top of the shifter: negates the amount for right-hand operations, rotates
// in a bit stage then a byte stage, merges fill, selects shift or adder word
// and registers it. Assumes W is a power of two and at least 8.
module rsh_shift_unit
    import rsh_pkg::*;
#(
    parameter int W = 32,
    localparam int AW = $clog2(W),
    localparam int CW = AW - 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  operand_i,
    input  logic [AW-1:0] amount_i,
    input  logic [2:0]    op_i,
    input  logic [W-1:0]  sum_i,
    input  logic          src_sel_i,
    output logic [W-1:0]  result_o
);
    logic          go_right;
    logic [AW-1:0] eff_amt;
    logic [W-1:0]  fine_q;
    logic [W-1:0]  coarse_q;
    logic [W-1:0]  merged;
    logic [W-1:0]  next_res;

    // Purpose: right-hand operations rotate left by (W - k) mod W.
    always_comb begin
        go_right = (op_i == OP_SRL) || (op_i == OP_SRA) || (op_i == OP_ROR);
        eff_amt  = go_right ? AW'(-amount_i) : amount_i;
    end

    rsh_bit_rotate #(.W(W)) u_fine (
        .d_i (operand_i),
        .n_i (eff_amt[2:0]),
        .q_o (fine_q)
    );

    rsh_byte_rotate #(.W(W)) u_coarse (
        .d_i (fine_q),
        .m_i (eff_amt[AW-1:3]),
        .q_o (coarse_q)
    );

    rsh_fill_merge #(.W(W)) u_merge (
        .rot_i  (coarse_q),
        .sign_i (operand_i[W-1]),
        .op_i   (op_i),
        .amt_i  (amount_i),
        .res_o  (merged)
    );

    // Purpose: shared final multiplexer between shifter and adder.
    always_comb next_res = src_sel_i ? sum_i : merged;

    // Purpose: result register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) result_o <= '0;
        else        result_o <= next_res;
    end
endmodule

// File: rtl/rsh_shift_unit_chk.sv
// Property checker for rsh_shift_unit, bound to every instance below.
module rsh_shift_unit_chk #(
    parameter int W = 32,
    localparam int AW = $clog2(W)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  operand_i,
    input logic [AW-1:0] amount_i,
    input logic [2:0]    op_i,
    input logic [W-1:0]  sum_i,
    input logic          src_sel_i,
    input logic [W-1:0]  result_o
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> result_o == '0);

    assert_adder_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        src_sel_i |=> result_o == $past(sum_i));

    // R2: the value follows the inputs of the previous edge.
    assert_sll_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sel_i && op_i == 3'd0) |=> result_o == $past(operand_i << amount_i));

    assert_srl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sel_i && op_i == 3'd1) |=> result_o == $past(operand_i >> amount_i));

    assert_sra_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sel_i && op_i == 3'd2) |=> result_o == $past(W'($signed(operand_i) >>> amount_i)));

    assert_rol_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sel_i && op_i == 3'd3) |=>
        result_o == $past((operand_i << amount_i) | (operand_i >> (W - int'(amount_i)))));

    assert_ror_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sel_i && op_i == 3'd4) |=>
        result_o == $past((operand_i >> amount_i) | (operand_i << (W - int'(amount_i)))));

    assert_zero_amt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sel_i && op_i <= 3'd4 && amount_i == '0) |=> result_o == $past(operand_i));

    assert_undef_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sel_i && op_i >= 3'd5) |=> result_o == '0);
endmodule

bind rsh_shift_unit rsh_shift_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .operand_i (operand_i),
    .amount_i  (amount_i),
    .op_i      (op_i),
    .sum_i     (sum_i),
    .src_sel_i (src_sel_i),
    .result_o  (result_o)
);

// File: tb/sim_rsh_shift_unit.sv
// Directed bench for rsh_shift_unit; one task per scenario.
module sim_rsh_shift_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] operand_i = '0;
    logic [4:0]  amount_i = '0;
    logic [2:0]  op_i = '0;
    logic [31:0] sum_i = '0;
    logic        src_sel_i = 1'b0;
    logic [31:0] result_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    rsh_shift_unit u0 (
        .clk(clk), .rst_n(rst_n), .operand_i(operand_i), .amount_i(amount_i),
        .op_i(op_i), .sum_i(sum_i), .src_sel_i(src_sel_i), .result_o(result_o)
    );

    // Reference model, bit by bit from the requirement text.
    function automatic logic [31:0] ref_val(input logic [2:0] op, input logic [31:0] a,
                                            input int k);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            case (op)
                3'd0: r[i] = (i < k) ? 1'b0 : a[i - k];
                3'd1: r[i] = (i + k < 32) ? a[i + k] : 1'b0;
                3'd2: r[i] = (i + k < 32) ? a[i + k] : a[31];
                3'd3: r[i] = a[(i - k + 32) % 32];
                3'd4: r[i] = a[(i + k) % 32];
                default: r[i] = 1'b0;
            endcase
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, wait for one rising edge, sample at the next falling edge.
    task automatic apply(input logic [2:0] op, input logic [31:0] a, input int k,
                         input logic [31:0] s, input logic sel);
        op_i = op; operand_i = a; amount_i = 5'(k); sum_i = s; src_sel_i = sel;
        @(negedge clk);
    endtask

    task automatic t_reset;
        apply(3'd3, 32'hDEAD_BEEF, 4, 32'h1234_5678, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears", result_o, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_latency;
        apply(3'd0, 32'h0000_00F0, 4, 32'h0, 1'b0);
        op_i = 3'd0; operand_i = 32'h0000_0001; amount_i = 5'd1;
        #5;
        check("R2 holds before edge", result_o, 32'h0000_0F00);
        @(negedge clk);
        check("R2 updates after edge", result_o, 32'h0000_0002);
    endtask

    task automatic t_adder;
        apply(3'd2, 32'h8000_0000, 31, 32'hCAFE_F00D, 1'b1);
        check("R3 adder pass", result_o, 32'hCAFE_F00D);
        apply(3'd6, 32'h1, 7, 32'h0BAD_0001, 1'b1);
        check("R3 adder pass unused op", result_o, 32'h0BAD_0001);
    endtask

    task automatic t_shifts;
        logic [31:0] pats [4] = '{32'h8765_4321, 32'h7FFF_0001, 32'hF000_000F, 32'h0000_0001};
        int amts [5] = '{1, 7, 8, 17, 31};
        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a < 5; a++) begin
                apply(3'd0, pats[p], amts[a], 32'h0, 1'b0);
                check("R4 SLL", result_o, ref_val(3'd0, pats[p], amts[a]));
                apply(3'd1, pats[p], amts[a], 32'h0, 1'b0);
                check("R5 SRL", result_o, ref_val(3'd1, pats[p], amts[a]));
                apply(3'd2, pats[p], amts[a], 32'h0, 1'b0);
                check("R6 SRA", result_o, ref_val(3'd2, pats[p], amts[a]));
            end
        end
        apply(3'd2, 32'h8000_0000, 31, 32'h0, 1'b0);
        check("R6 SRA sign 31", result_o, 32'hFFFF_FFFF);
    endtask

    task automatic t_rotates;
        logic [31:0] a = 32'h8C3A_51E7;
        for (int k = 0; k < 32; k++) begin
            apply(3'd3, a, k, 32'h0, 1'b0);
            check("R7 R11 ROL sweep", result_o, ref_val(3'd3, a, k));
            apply(3'd4, a, k, 32'h0, 1'b0);
            check("R8 R11 ROR sweep", result_o, ref_val(3'd4, a, k));
        end
    endtask

    task automatic t_zero_amt;
        for (int op = 0; op < 5; op++) begin
            apply(3'(op), 32'hA5C3_9E01, 0, 32'hFFFF_FFFF, 1'b0);
            check("R9 zero amount", result_o, 32'hA5C3_9E01);
        end
    endtask

    task automatic t_unused;
        for (int op = 5; op < 8; op++) begin
            apply(3'(op), 32'hFFFF_FFFF, 3, 32'h1111_1111, 1'b0);
            check("R10 unused op", result_o, 32'h0);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset state", result_o, 32'h0);
        rst_n = 1'b1;
        t_latency();
        t_adder();
        t_shifts();
        t_rotates();
        t_zero_amt();
        t_unused();
        t_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule